// File: doc/BRIEF.md
# Tachometer Error Fan Boost Controller

This block sits between the tachometer monitors and the PWM fan drivers of a fan control subsystem. It watches four per-tachometer error flags and, when an error appears that is not explained by the state of the fan's own PWM channel, raises a request that forces the fan drive to full duty. A tachometer can be tied to either or both of two PWM channels through a binding register. While any PWM bound to a tachometer sits at zero duty or is spinning its fan up, that tachometer's error is ignored, because a stopped or accelerating fan is expected to report a bad speed.

A second register sets how long the full-duty request persists after the last error goes away. The release is timed in units of thirty-two periods of an external base tick strobe. One code of the timeout field turns the feature off and another makes the boost latch until software clears its status bit. The status bit and the timeout field are read back through the same simple register port that writes them.

Top module: `tach_boost`

## Requirements
- R1: The binding register sits at address 0, resets to 00h and reads back as written; bit 2k ties tachometer k+1 (k = 0..3) to PWM channel 1 and bit 2k+1 ties it to PWM channel 2.
- R2: The control register sits at address 1 and resets to 3Fh; bits 5:0 hold the timeout field, bit 6 is the boost status and bit 7 always reads 0 whatever is written to it.
- R3: A tachometer error is masked while any PWM channel it is bound to reports zero duty or spin-up, including a tachometer bound to both channels; an error on a tachometer with no binding is never masked.
- R4: With the feature enabled, an unmasked error at a clock edge makes `boostReq` and the status bit read 1 from that edge on.
- R5: A timeout field of 63 disables the feature: `boostReq` stays 0 and the status bit reads 0 whatever the error inputs do.
- R6: For a timeout field N in 1..62, the boost holds while any unmasked error is present and ends at the edge that samples the 32×N-th tick strobe counted after the last error-carrying edge; a new error restarts the count.
- R7: With a timeout field of 0 the boost never times out; a write to address 1 that keeps the field at 0 and has bit 6 at 0 ends it, but only if no unmasked error is present in that cycle.
- R8: With a timeout field other than 0, writing bit 6 (either value) with an unchanged field leaves the boost state unchanged.
- R9: A write to address 1 that changes the timeout field ends any active boost at that edge and restarts the timeout count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tachErr | input | 4 | Error flag per tachometer, bit k for tachometer k+1 |
| pwmZero | input | 2 | Per-PWM channel: duty is currently 0% |
| pwmSpinUp | input | 2 | Per-PWM channel: spin-up in progress |
| tick | input | 1 | One-cycle base tick strobe |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 binding, 1 boost control |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for the selected register |
| boostReq | output | 1 | Request for 100% PWM duty |

## Verification
The assertions take the error, zero-duty, spin-up and tick inputs to be synchronous to `clk` and the tick to be a single-cycle strobe, so that each edge sees one settled value of each. They also take a register write to last exactly one cycle and the address to carry only the two defined values. The stimulus changes every input on the falling edge, pulses `regWrEn` for a single cycle per write and drives `tick` either every cycle or on a fixed subset of cycles, so all of this holds throughout the run.

// File: rtl/tach_boost_pkg.sv
package tach_boost_pkg;

  // Commands from the control half to the timeout counter in the datapath
  typedef struct packed {
    logic reload;
    logic decr;
    logic clear;
  } cntStrobe_t;

  typedef enum logic {
    ADDR_BIND  = 1'b0,
    ADDR_BOOST = 1'b1
  } regAddr_e;

endpackage

// File: rtl/tach_mask.sv
module tach_mask #(
  parameter int NUM_TACH = 4,
  parameter int NUM_PWM  = 2,
  localparam int BIND_W  = NUM_TACH * NUM_PWM
) (
  input  logic [BIND_W-1:0]   bindReg,
  input  logic [NUM_TACH-1:0] tachErr,
  input  logic [NUM_PWM-1:0]  pwmZero,
  input  logic [NUM_PWM-1:0]  pwmSpinUp,
  output logic                errLive
);

  logic [NUM_PWM-1:0]  pwmQuiet;
  logic [NUM_TACH-1:0] liveErr;

  assign pwmQuiet = pwmZero | pwmSpinUp;

  for (genvar t = 0; t < NUM_TACH; t++) begin : g_tach
    logic [NUM_PWM-1:0] boundQuiet;
    // any bound channel that is stopped or accelerating hides the error
    assign boundQuiet = bindReg[t*NUM_PWM +: NUM_PWM] & pwmQuiet;
    assign liveErr[t] = tachErr[t] & ~(|boundQuiet);
  end

  assign errLive = |liveErr;

endmodule

// File: rtl/tach_boost_dp.sv
module tach_boost_dp
  import tach_boost_pkg::*;
#(
  parameter int REG_W      = 8,
  parameter int TBT_W      = 6,
  parameter int UNIT_SHIFT = 5,
  parameter int BIND_W     = 8,
  localparam int CNT_W     = TBT_W + UNIT_SHIFT,
  localparam int STATUS_BIT = TBT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regAddr,
  input  logic [REG_W-1:0] regWrData,
  input  cntStrobe_t       cntCmd,
  input  logic             boostActive,
  output logic [BIND_W-1:0] bindReg,
  output logic [TBT_W-1:0] tbtField,
  output logic             cntIsOne,
  output logic             fieldChange,
  output logic             statusClr,
  output logic             featureOff,
  output logic             infiniteMode,
  output logic [REG_W-1:0] regRdData
);

  localparam logic [TBT_W-1:0] OFF_CODE = '1;
  localparam logic [TBT_W-1:0] INF_CODE = '0;

  logic             bindWr;
  logic             ctlWr;
  logic [CNT_W-1:0] cnt;

  assign bindWr = regWrEn && (regAddr == ADDR_BIND);
  assign ctlWr  = regWrEn && (regAddr == ADDR_BOOST);

  assign fieldChange  = ctlWr && (regWrData[TBT_W-1:0] != tbtField);
  assign statusClr    = ctlWr && (regWrData[TBT_W-1:0] == tbtField) && !regWrData[STATUS_BIT];
  assign featureOff   = (tbtField == OFF_CODE);
  assign infiniteMode = (tbtField == INF_CODE);
  assign cntIsOne     = (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bindReg <= '0;
    end else if (bindWr) begin
      bindReg <= regWrData[BIND_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tbtField <= OFF_CODE;
    end else if (ctlWr) begin
      tbtField <= regWrData[TBT_W-1:0];
    end
  end

  // timeout counter in base ticks: field value times 2**UNIT_SHIFT
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (cntCmd.clear) begin
      cnt <= '0;
    end else if (cntCmd.reload) begin
      cnt <= {tbtField, {UNIT_SHIFT{1'b0}}};
    end else if (cntCmd.decr) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_BIND) begin
      regRdData[BIND_W-1:0] = bindReg;
    end else begin
      regRdData[TBT_W-1:0]  = tbtField;
      regRdData[STATUS_BIT] = boostActive && !featureOff;
    end
  end

endmodule

// File: rtl/tach_boost_ctl.sv
module tach_boost_ctl
  import tach_boost_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       errLive,
  input  logic       featureOff,
  input  logic       infiniteMode,
  input  logic       fieldChange,
  input  logic       statusClr,
  input  logic       tick,
  input  logic       cntIsOne,
  output cntStrobe_t cntCmd,
  output logic       boostActive
);

  logic activeNext;

  always_comb begin
    cntCmd     = '0;
    activeNext = boostActive;
    if (fieldChange || featureOff) begin
      activeNext   = 1'b0;
      cntCmd.clear = 1'b1;
    end else if (errLive) begin
      activeNext    = 1'b1;
      cntCmd.reload = !infiniteMode;
    end else if (boostActive) begin
      if (infiniteMode) begin
        if (statusClr) begin
          activeNext = 1'b0;
        end
      end else if (tick) begin
        if (cntIsOne) begin
          activeNext   = 1'b0;
          cntCmd.clear = 1'b1;
        end else begin
          cntCmd.decr = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      boostActive <= 1'b0;
    end else begin
      boostActive <= activeNext;
    end
  end

endmodule

// File: rtl/tach_boost.sv
module tach_boost
  import tach_boost_pkg::*;
#(
  parameter int NUM_TACH   = 4,
  parameter int NUM_PWM    = 2,
  parameter int REG_W      = 8,
  parameter int TBT_W      = 6,
  parameter int UNIT_SHIFT = 5,
  localparam int BIND_W    = NUM_TACH * NUM_PWM
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_TACH-1:0] tachErr,
  input  logic [NUM_PWM-1:0]  pwmZero,
  input  logic [NUM_PWM-1:0]  pwmSpinUp,
  input  logic                tick,
  input  logic                regWrEn,
  input  logic                regAddr,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  output logic                boostReq
);

  logic [BIND_W-1:0] bindReg;
  logic [TBT_W-1:0]  tbtField;
  logic              errLive;
  logic              cntIsOne;
  logic              fieldChange;
  logic              statusClr;
  logic              featureOff;
  logic              infiniteMode;
  logic              boostActive;
  cntStrobe_t        cntCmd;

  tach_mask #(
    .NUM_TACH (NUM_TACH),
    .NUM_PWM  (NUM_PWM)
  ) u_mask (
    .bindReg   (bindReg),
    .tachErr   (tachErr),
    .pwmZero   (pwmZero),
    .pwmSpinUp (pwmSpinUp),
    .errLive   (errLive)
  );

  tach_boost_dp #(
    .REG_W      (REG_W),
    .TBT_W      (TBT_W),
    .UNIT_SHIFT (UNIT_SHIFT),
    .BIND_W     (BIND_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .regWrEn      (regWrEn),
    .regAddr      (regAddr),
    .regWrData    (regWrData),
    .cntCmd       (cntCmd),
    .boostActive  (boostActive),
    .bindReg      (bindReg),
    .tbtField     (tbtField),
    .cntIsOne     (cntIsOne),
    .fieldChange  (fieldChange),
    .statusClr    (statusClr),
    .featureOff   (featureOff),
    .infiniteMode (infiniteMode),
    .regRdData    (regRdData)
  );

  tach_boost_ctl u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .errLive      (errLive),
    .featureOff   (featureOff),
    .infiniteMode (infiniteMode),
    .fieldChange  (fieldChange),
    .statusClr    (statusClr),
    .tick         (tick),
    .cntIsOne     (cntIsOne),
    .cntCmd       (cntCmd),
    .boostActive  (boostActive)
  );

  assign boostReq = boostActive;

endmodule

// File: rtl/tach_boost_chk.sv
module tach_boost_chk #(
  parameter int TBT_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             boostReq,
  input logic             errLive,
  input logic             tick,
  input logic             regWrEn,
  input logic             regAddr,
  input logic [TBT_W-1:0] wrField,
  input logic             rdTopBit,
  input logic [TBT_W-1:0] tbtField
);

  localparam logic [TBT_W-1:0] OFF_CODE = '1;
  localparam logic [TBT_W-1:0] INF_CODE = '0;

  logic ctlWr;
  logic fieldChg;
  logic isOff;

  assign ctlWr    = regWrEn && regAddr;
  assign fieldChg = ctlWr && (wrField != tbtField);
  assign isOff    = (tbtField == OFF_CODE);

  p_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    (errLive && !isOff && !fieldChg) |=> boostReq);

  p_rise_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(boostReq) |-> $past(errLive));

  p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    isOff |-> !boostReq);

  p_finite_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (boostReq && !errLive && !tick && !ctlWr && tbtField != INF_CODE) |=> boostReq);

  p_infinite_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (boostReq && !ctlWr && tbtField == INF_CODE) |=> boostReq);

  p_cancel_r9: assert property (@(posedge clk) disable iff (!rstN)
    fieldChg |=> !boostReq);

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    regAddr |-> !rdTopBit);

endmodule

bind tach_boost tach_boost_chk #(.TBT_W(TBT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .boostReq (boostReq),
  .errLive  (errLive),
  .tick     (tick),
  .regWrEn  (regWrEn),
  .regAddr  (regAddr),
  .wrField  (regWrData[TBT_W-1:0]),
  .rdTopBit (regRdData[REG_W-1]),
  .tbtField (tbtField)
);

// File: tb/tach_boost_tb.sv
module tach_boost_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] tachErr = '0;
  logic [1:0] pwmZero = '0;
  logic [1:0] pwmSpinUp = '0;
  logic       tick = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regAddr = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       boostReq;

  int    checks = 0;
  int    errors = 0;
  string phase = "R1";
  bit    done = 1'b0;

  // reference model state
  int mBind = 0;
  int mTbt = 63;
  int mRemain = 0;
  bit mActive = 1'b0;

  tach_boost u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .tachErr   (tachErr),
    .pwmZero   (pwmZero),
    .pwmSpinUp (pwmSpinUp),
    .tick      (tick),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .boostReq  (boostReq)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit modelErr();
    bit anyErr = 1'b0;
    for (int k = 0; k < 4; k++) begin
      bit hidden;
      hidden = (mBind[2*k]   && (pwmZero[0] || pwmSpinUp[0])) ||
               (mBind[2*k+1] && (pwmZero[1] || pwmSpinUp[1]));
      if (tachErr[k] && !hidden) anyErr = 1'b1;
    end
    return anyErr;
  endfunction

  function automatic int modelRead();
    if (!regAddr) return mBind;
    return mTbt + ((mActive && mTbt != 63) ? 64 : 0);
  endfunction

  // reference model advances on each rising edge, comparison 2 ns later
  always @(posedge clk) begin
    if (!rstN) begin
      mBind = 0; mTbt = 63; mRemain = 0; mActive = 1'b0;
    end else begin
      bit e;
      bit ctl;
      int newField;
      e = modelErr();
      ctl = regWrEn && regAddr;
      newField = int'(regWrData[5:0]);
      if (ctl && newField != mTbt) begin
        mActive = 1'b0; mRemain = 0; mTbt = newField;
      end else if (mTbt == 63) begin
        mActive = 1'b0;
      end else if (e) begin
        mActive = 1'b1; mRemain = mTbt * 32;
      end else if (mActive) begin
        if (mTbt == 0) begin
          if (ctl && !regWrData[6]) mActive = 1'b0;
        end else if (tick) begin
          mRemain = mRemain - 1;
          if (mRemain == 0) mActive = 1'b0;
        end
      end
      if (regWrEn && !regAddr) mBind = int'(regWrData);
    end
    #2;
    if (rstN && !done) begin
      check(boostReq == mActive, {phase, " boostReq vs model"}, boostReq, mActive);
      check(int'(regRdData) == modelRead(), {phase, " read data vs model"}, regRdData, modelRead());
    end
  end

  task automatic wr(input bit a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expBoost(input bit exp, input string tag);
    check(boostReq == exp, tag, boostReq, exp);
  endtask

  task automatic expRead(input bit a, input int exp, input string tag);
    regAddr = a;
    #1;
    check(int'(regRdData) == exp, tag, regRdData, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog phase %s actual=hung expected=finished", phase);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    // reset values
    expRead(1'b0, 'h00, "R1 reset binding");
    expRead(1'b1, 'h3F, "R2 reset control");
    expBoost(1'b0, "R5 reset boost");

    phase = "R1";
    wr(1'b0, 8'hA5);
    expRead(1'b0, 'hA5, "R1 binding readback");
    wr(1'b0, 8'h00);

    phase = "R2";
    wr(1'b1, 8'hC5);
    expRead(1'b1, 'h05, "R2 reserved and status write");

    phase = "R5";
    wr(1'b1, 8'h3F);
    tachErr = 4'hF;
    idle(5);
    expBoost(1'b0, "R5 disabled boost");
    expRead(1'b1, 'h3F, "R5 disabled status");
    tachErr = 4'h0;

    phase = "R4";
    wr(1'b1, 8'h02);
    tachErr = 4'b0100;
    idle(1);
    expBoost(1'b1, "R4 boost starts");
    expRead(1'b1, 'h42, "R4 status set");

    phase = "R6";
    tachErr = 4'h0;
    tick = 1'b1;
    idle(63);
    expBoost(1'b1, "R6 still boosting after 63 ticks");
    idle(1);
    expBoost(1'b0, "R6 ends at 64th tick");
    // sparse ticks with an error pulse in the middle of the count
    tachErr = 4'b0001;
    idle(2);
    tachErr = 4'h0;
    for (int i = 0; i < 300; i++) begin
      tick = (i % 4 == 0);
      if (i == 100) tachErr = 4'b1000;
      if (i == 101) tachErr = 4'h0;
      idle(1);
    end
    tick = 1'b0;

    phase = "R3";
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h8D);
    pwmZero = 2'b01;
    tachErr = 4'b0001;
    idle(3);
    expBoost(1'b0, "R3 tach1 masked by zero duty");
    tachErr = 4'b0010;
    idle(3);
    expBoost(1'b0, "R3 double binding masked");
    pwmZero = 2'b00;
    pwmSpinUp = 2'b10;
    tachErr = 4'b1000;
    idle(3);
    expBoost(1'b0, "R3 tach4 masked by spin-up");
    tachErr = 4'b0100;
    idle(1);
    expBoost(1'b1, "R3 unbound tach3 not masked");
    tachErr = 4'b0000;
    pwmSpinUp = 2'b00;

    phase = "R9";
    wr(1'b1, 8'h02);
    expBoost(1'b0, "R9 field change cancels");

    phase = "R8";
    tachErr = 4'b0001;
    idle(1);
    tachErr = 4'b0000;
    wr(1'b1, 8'h02);
    expBoost(1'b1, "R8 status clear ignored in finite mode");
    wr(1'b1, 8'h42);
    expBoost(1'b1, "R8 status set write harmless");

    phase = "R7";
    wr(1'b1, 8'h00);
    tachErr = 4'b0001;
    idle(2);
    tachErr = 4'b0000;
    tick = 1'b1;
    idle(100);
    expBoost(1'b1, "R7 infinite boost holds");
    tachErr = 4'b0001;
    wr(1'b1, 8'h00);
    expBoost(1'b1, "R7 clear refused while error present");
    tachErr = 4'b0000;
    wr(1'b1, 8'h40);
    expBoost(1'b1, "R7 writing status 1 keeps boost");
    wr(1'b1, 8'h00);
    expBoost(1'b0, "R7 software clear ends boost");
    tick = 1'b0;

    phase = "R2";
    wr(1'b1, 8'h80);
    expRead(1'b1, 'h00, "R2 reserved bit reads 0");

    idle(4);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule